// File: doc/BRIEF.md
# Graphics Page and Nametable Bank Mapper

This block turns a 14-bit graphics-bus address into one of two targets: a byte address in a 256 KB pattern ROM made of 1 KB pages, or a select of the console's own 2 KB nametable RAM with its A10 line. The 16 KB graphics space is cut into twelve 1 KB regions. Eight regions cover the two pattern tables and four cover the nametables. Each region has a page register that the CPU writes through a write bus.

A page value from $E0 to $FF can send its region to nametable RAM instead of ROM. Bit 0 of the value picks one of the two RAM pages. For each pattern-table half, this redirection can be switched off by a bit in the control register at CPU $E800-$EFFF. When it is off, those values simply reach the top 32 ROM pages. The nametable regions can always reach RAM, so software builds any mirroring arrangement by writing four page registers.

The register state is sequential and the address translation is purely combinational. A graphics address presented in a cycle is translated in that same cycle.

Top module: `chr_bank_mapper`

## Requirements
- R1: A CPU write to $8000-$DFFF stores wr_data_i into page register k = wr_addr_i[14:11] (k = 0..11). Register k serves graphics region k, which spans k*$400 to k*$400+$3FF.
- R2: rom_addr_o always equals {page of the addressed region, ppu_addr_i[9:0]}. This gives 18 bits, with the page in bits 17:10.
- R3: A page value below $E0 gives rom_sel_o=1 and ntram_ce_o=0 in every region.
- R4: A page value of $E0-$FF in a region where RAM is allowed gives ntram_ce_o=1 and rom_sel_o=0, with ntram_a10_o equal to bit 0 of the page.
- R5: A write to $E800-$EFFF stores data bit 6 as the RAM disable for graphics $0000-$0FFF. While that bit is set, page values of $E0-$FF there select ROM.
- R6: Data bit 7 of the same write is the RAM disable for graphics $1000-$1FFF. It is independent of bit 6.
- R7: Regions $2000-$2FFF allow RAM whatever the disable bits hold. The pages E0,E0,E1,E1 give horizontal mirroring and E0,E1,E0,E1 give vertical mirroring.
- R8: Graphics addresses $3000-$3FFF use the regions of $2000-$2FFF.
- R9: rst_ni low clears all page registers and both disable bits.
- R10: Writes with wr_en_i low, and writes to addresses outside $8000-$DFFF and $E800-$EFFF, change no page and no disable bit.
- R11: Exactly one of rom_sel_o and ntram_ce_o is high at all times.
- R12: A register write is visible at the outputs in the cycle after the clock edge that takes it. The outputs follow ppu_addr_i without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| ppu_addr_i | input | 14 | Graphics-bus address |
| rom_addr_o | output | 18 | Pattern ROM byte address |
| rom_sel_o | output | 1 | Pattern ROM select |
| ntram_ce_o | output | 1 | Nametable RAM chip enable |
| ntram_a10_o | output | 1 | Nametable RAM page line |

## Verification
A corrupt page register shows up at once as a wrong upper ROM address, or as a wrong target, for any graphics address in its region. It stays invisible until the address lands there, so the stimulus sweeps every region after each change to the configuration. A stuck or swapped disable bit shows only when a page of $E0 or above sits in the affected half. For that reason, pages at both parities are kept in both halves while the bits are toggled. Register decode errors show up one cycle after the write, as a changed page in a region that should have kept its old one.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned OFF_W    = 10;
  localparam int unsigned N_REG    = 12;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned PPU_W    = 14;
  localparam int unsigned CPU_W    = 16;
  localparam logic [2:0]  RAM_TAG  = 3'b111;

  typedef enum logic [1:0] {
    HALF_LO = 2'd0,
    HALF_HI = 2'd1,
    HALF_NT = 2'd2
  } half_e;
endpackage

// File: rtl/chr_page_regs.sv
module chr_page_regs
  import chr_map_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NREG = N_REG,
  parameter int unsigned AW   = CPU_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [NREG-1:0][DW-1:0] pages_o,
  output logic                dis_lo_o,
  output logic                dis_hi_o
);
  localparam int unsigned WIN_W = 5;
  localparam logic [WIN_W-1:0] CTRL_WIN = 5'b11101;

  logic [WIN_W-1:0] win;
  logic             page_win;
  logic             ctrl_hit;

  assign win      = wr_addr_i[AW-1 -: WIN_W];
  assign page_win = win[WIN_W-1] && ({1'b0, win[WIN_W-2:0]} < WIN_W'(NREG));
  assign ctrl_hit = wr_en_i && (win == CTRL_WIN);

  for (genvar k = 0; k < NREG; k++) begin : g_page
    logic hit;
    assign hit = wr_en_i && page_win && (win[WIN_W-2:0] == (WIN_W-1)'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pages_o[k] <= '0;
      else if (hit) pages_o[k] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_lo_o <= 1'b0;
      dis_hi_o <= 1'b0;
    end else if (ctrl_hit) begin
      dis_lo_o <= wr_data_i[6];
      dis_hi_o <= wr_data_i[7];
    end
  end
endmodule

// File: rtl/chr_region_sel.sv
module chr_region_sel
  import chr_map_pkg::*;
#(
  parameter int unsigned PW = PPU_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic [PW-1:0] ppu_addr_i,
  output logic [IW-1:0] idx_o,
  output half_e         half_o
);
  // $3000-$3FFF folds onto the nametable regions
  always_comb begin
    if (ppu_addr_i[13]) begin
      idx_o  = IW'({2'b10, ppu_addr_i[11:10]});
      half_o = HALF_NT;
    end else begin
      idx_o  = IW'(ppu_addr_i[12:10]);
      half_o = ppu_addr_i[12] ? HALF_HI : HALF_LO;
    end
  end
endmodule

// File: rtl/chr_page_resolve.sv
module chr_page_resolve
  import chr_map_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned OW = OFF_W
) (
  input  logic [DW-1:0]    page_i,
  input  logic [OW-1:0]    off_i,
  input  half_e            half_i,
  input  logic             dis_lo_i,
  input  logic             dis_hi_i,
  output logic [DW+OW-1:0] rom_addr_o,
  output logic             rom_sel_o,
  output logic             ntram_ce_o,
  output logic             ntram_a10_o
);
  logic ram_page;
  logic ram_ok;

  assign ram_page = (page_i[DW-1 -: 3] == RAM_TAG);

  always_comb begin
    unique case (half_i)
      HALF_LO: ram_ok = !dis_lo_i;
      HALF_HI: ram_ok = !dis_hi_i;
      default: ram_ok = 1'b1;
    endcase
  end

  assign rom_addr_o  = {page_i, off_i};
  assign ntram_ce_o  = ram_page && ram_ok;
  assign rom_sel_o   = !ntram_ce_o;
  assign ntram_a10_o = page_i[0];
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned OW   = OFF_W,
  parameter int unsigned NREG = N_REG,
  parameter int unsigned PW   = PPU_W,
  parameter int unsigned AW   = CPU_W,
  localparam int unsigned RW  = DW + OW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [PW-1:0] ppu_addr_i,
  output logic [RW-1:0] rom_addr_o,
  output logic          rom_sel_o,
  output logic          ntram_ce_o,
  output logic          ntram_a10_o
);
  logic [NREG-1:0][DW-1:0] pages;
  logic                    dis_lo, dis_hi;
  logic [IDX_W-1:0]        idx;
  half_e                   half;
  logic [DW-1:0]           cur_page;

  chr_page_regs #(.DW(DW), .NREG(NREG), .AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .pages_o   (pages),
    .dis_lo_o  (dis_lo),
    .dis_hi_o  (dis_hi)
  );

  chr_region_sel #(.PW(PW), .IW(IDX_W)) u_region (
    .ppu_addr_i (ppu_addr_i),
    .idx_o      (idx),
    .half_o     (half)
  );

  always_comb begin
    cur_page = '0;
    for (int k = 0; k < NREG; k++)
      if (idx == IDX_W'(k)) cur_page = pages[k];
  end

  chr_page_resolve #(.DW(DW), .OW(OW)) u_resolve (
    .page_i      (cur_page),
    .off_i       (ppu_addr_i[OW-1:0]),
    .half_i      (half),
    .dis_lo_i    (dis_lo),
    .dis_hi_i    (dis_hi),
    .rom_addr_o  (rom_addr_o),
    .rom_sel_o   (rom_sel_o),
    .ntram_ce_o  (ntram_ce_o),
    .ntram_a10_o (ntram_a10_o)
  );
endmodule

// File: rtl/chr_bank_mapper_chk.sv
module chr_bank_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_addr_i,
  input logic [7:0]  wr_data_i,
  input logic [13:0] ppu_addr_i,
  input logic [17:0] rom_addr_o,
  input logic        rom_sel_o,
  input logic        ntram_ce_o,
  input logic        ntram_a10_o
);
  logic ctrl_wr;
  logic hi_page;
  assign ctrl_wr = wr_en_i && (wr_addr_i[15:11] == 5'b11101);
  assign hi_page = (rom_addr_o[17:15] == 3'b111);

  assert_one_target_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_sel_o != ntram_ce_o);

  assert_offset_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[9:0] == ppu_addr_i[9:0]);

  assert_low_page_rom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_page |-> rom_sel_o);

  assert_ram_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntram_ce_o |-> (hi_page && (ntram_a10_o == rom_addr_o[10])));

  assert_lo_disable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wr_data_i[6]) |=> (ppu_addr_i[13:12] != 2'b00 || rom_sel_o));

  assert_hi_disable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wr_data_i[7]) |=> (ppu_addr_i[13:12] != 2'b01 || rom_sel_o));

  assert_nt_always_ram_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppu_addr_i[13] && hi_page) |-> ntram_ce_o);
endmodule

bind chr_bank_mapper chr_bank_mapper_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .ppu_addr_i  (ppu_addr_i),
  .rom_addr_o  (rom_addr_o),
  .rom_sel_o   (rom_sel_o),
  .ntram_ce_o  (ntram_ce_o),
  .ntram_a10_o (ntram_a10_o)
);

// File: tb/chr_bank_mapper_test.sv
`timescale 1ns/1ps
module chr_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [13:0] ppu_addr = '0;
  logic [17:0] rom_addr;
  logic        rom_sel, ntram_ce, ntram_a10;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chr_bank_mapper uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .ppu_addr_i  (ppu_addr),
    .rom_addr_o  (rom_addr),
    .rom_sel_o   (rom_sel),
    .ntram_ce_o  (ntram_ce),
    .ntram_a10_o (ntram_a10)
  );

  // {ppu addr, rom addr, rom_sel, ntram_ce, a10}
  localparam logic [34:0] VEC [14] = '{
    {14'h0005, 18'h04805, 1'b1, 1'b0, 1'b0},
    {14'h0400, 18'h38000, 1'b0, 1'b1, 1'b0},
    {14'h0BFF, 18'h387FF, 1'b0, 1'b1, 1'b1},
    {14'h0C10, 18'h37C10, 1'b1, 1'b0, 1'b1},
    {14'h1000, 18'h3FC00, 1'b0, 1'b1, 1'b1},
    {14'h1555, 18'h38955, 1'b0, 1'b1, 1'b0},
    {14'h1801, 18'h01401, 1'b1, 1'b0, 1'b1},
    {14'h1FFF, 18'h38FFF, 1'b0, 1'b1, 1'b1},
    {14'h2000, 18'h38000, 1'b0, 1'b1, 1'b0},
    {14'h2400, 18'h38000, 1'b0, 1'b1, 1'b0},
    {14'h2800, 18'h38400, 1'b0, 1'b1, 1'b1},
    {14'h2FFF, 18'h387FF, 1'b0, 1'b1, 1'b1},
    {14'h3C01, 18'h38401, 1'b0, 1'b1, 1'b1},
    {14'h3400, 18'h38000, 1'b0, 1'b1, 1'b0}
  };

  localparam logic [7:0] INIT_PAGE [12] = '{
    8'h12, 8'hE0, 8'hE1, 8'hDF, 8'hFF, 8'hE2, 8'h05, 8'hE3,
    8'hE0, 8'hE0, 8'hE1, 8'hE1
  };

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = en;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [13:0] pa, input logic [17:0] ea,
                       input logic es, input logic ec, input logic e10, input string req);
    ppu_addr = pa;
    #1;
    checks++;
    if (rom_addr !== ea || rom_sel !== es || ntram_ce !== ec || (ec && ntram_a10 !== e10)) begin
      errors++;
      $display("FAIL %s ppu=%h: got addr=%h sel=%b ce=%b a10=%b, want addr=%h sel=%b ce=%b a10=%b",
               req, pa, rom_addr, rom_sel, ntram_ce, ntram_a10, ea, es, ec, e10);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, want completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state, all pages zero
    probe(14'h2000, 18'h00000, 1'b1, 1'b0, 1'b0, "R9");
    probe(14'h0400, 18'h00000, 1'b1, 1'b0, 1'b0, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    probe(14'h1ABC, 18'h002BC, 1'b1, 1'b0, 1'b0, "R9");

    // R1: page registers via their windows
    for (int k = 0; k < 12; k++) cpu_write(16'h8000 + 16'(k) * 16'h0800, INIT_PAGE[k]);
    // R12: write visible the cycle after
    probe(14'h3C00, 18'h38400, 1'b0, 1'b1, 1'b1, "R12");

    // R2 R3 R4 R7 R8 table
    for (int i = 0; i < 14; i++)
      probe(VEC[i][34:21], VEC[i][20:3], VEC[i][2], VEC[i][1], VEC[i][0], "R1/R2/R3/R4/R7/R8");

    // R5: low half disable
    cpu_write(16'hE800, 8'h40);
    probe(14'h0400, 18'h38000, 1'b1, 1'b0, 1'b0, "R5");
    probe(14'h1000, 18'h3FC00, 1'b0, 1'b1, 1'b1, "R6");
    // R6: high half only
    cpu_write(16'hEFFF, 8'h80);
    probe(14'h0BFF, 18'h387FF, 1'b0, 1'b1, 1'b1, "R5");
    probe(14'h1FFF, 18'h38FFF, 1'b1, 1'b0, 1'b0, "R6");
    // R7: nametables ignore both disables
    cpu_write(16'hE800, 8'hC0);
    probe(14'h2800, 18'h38400, 1'b0, 1'b1, 1'b1, "R7");
    probe(14'h0400, 18'h38000, 1'b1, 1'b0, 1'b0, "R5");

    // R10: writes outside the windows and strobe-less writes
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'hF000, 8'h00);
    cpu_write(16'hF800, 8'h00);
    cpu_write(16'h7800, 8'h00);
    cpu_write(16'h5800, 8'h00);
    cpu_write(16'h8000, 8'h77, 1'b0);
    cpu_write(16'hE800, 8'h00, 1'b0);
    probe(14'h0005, 18'h04805, 1'b1, 1'b0, 1'b0, "R10");
    probe(14'h1000, 18'h3FC00, 1'b1, 1'b0, 1'b0, "R10");
    probe(14'h0C10, 18'h37C10, 1'b1, 1'b0, 1'b0, "R10");

    // R7: vertical mirroring, last address of windows
    cpu_write(16'hC7FF, 8'hE0);
    cpu_write(16'hCFFF, 8'hE1);
    cpu_write(16'hD7FF, 8'hE0);
    cpu_write(16'hDFFF, 8'hE1);
    probe(14'h2400, 18'h38400, 1'b0, 1'b1, 1'b1, "R7");
    probe(14'h2800, 18'h38000, 1'b0, 1'b1, 1'b0, "R7");
    probe(14'h3C00, 18'h38400, 1'b0, 1'b1, 1'b1, "R8");

    // R3/R4 boundary at $DF/$E0
    cpu_write(16'hE800, 8'h00);
    cpu_write(16'h8000, 8'hE0);
    probe(14'h0000, 18'h38000, 1'b0, 1'b1, 1'b0, "R4");
    cpu_write(16'h87FF, 8'hDF);
    probe(14'h0000, 18'h37C00, 1'b1, 1'b0, 1'b0, "R3");

    // R9: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    probe(14'h2C00, 18'h00000, 1'b1, 1'b0, 1'b0, "R9");
    @(negedge clk);
    rst_n = 1'b1;
    cpu_write(16'h9800, 8'hE3);
    probe(14'h0C00, 18'h38C00, 1'b0, 1'b1, 1'b1, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule